// File: doc/BRIEF.md
# Cascaded Conversion Pacer Timer

This block issues periodic conversion-start strobes for an analog-input sampler. A fixed base tick is derived from the system clock by a prescaler. The default is one tick every 25 system clocks, which gives a 2 MHz time base from a 50 MHz clock. Two down-counters run in periodic rate-generator mode with binary counting. The low counter divides the base tick, and each of its reload pulses steps the high counter. The high counter's reload pulse becomes the conversion strobe.

A small write port programs the block. A mode write selects the strobe source and always stops the pacer, so the pacer can be put in a known idle state without new divisors. The low divisor must be written first. A later high-divisor write then loads both counters and starts the chain. When external source is selected, a synchronized rising edge on the trigger input produces the strobe instead of the internal chain.

Top module: `pacer_cascade`

## Requirements
- R1: After a synchronous reset, `running` and `conv_strobe` are 0 and both counters are cleared.
- R2: A write with `wr_sel`=0 (mode) copies `wr_data[0]` into the source select (1 = external, 0 = internal) and stops the pacer. `running` is 0 from the next cycle, and no strobe is emitted while stopped.
- R3: A write with `wr_sel`=2 (high divisor) arms the pacer only if a write with `wr_sel`=1 (low divisor) came after the last mode write or arming. A high-divisor write without such a low-divisor write leaves the pacer stopped.
- R4: With internal source, the first strobe is high in the cycle after clock edge TICK_DIV*LOW*HIGH, counting the arming edge as edge 0. Strobes then repeat every TICK_DIV*LOW*HIGH cycles.
- R5: A divisor value of 0 or 1 is treated as 2.
- R6: `conv_strobe` is never high for two consecutive cycles.
- R7: With external source and the pacer running, a rising edge of `ext_trig` gives exactly one strobe, three clock edges after the input rises. The internal chain gives no strobe in this mode, and nothing is emitted when the pacer is stopped.
- R8: A write with `wr_sel`=3 has no effect.
- R9: Divisors are captured at arming. A low-divisor write while running does not change the strobe period until the pacer is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the programming port |
| wr_sel | input | 2 | Target: 0 mode, 1 low divisor, 2 high divisor and arm, 3 unused |
| wr_data | input | CNT_W | Write data |
| ext_trig | input | 1 | Asynchronous external trigger |
| conv_strobe | output | 1 | One-cycle conversion-start strobe |
| running | output | 1 | Pacer armed |

## Verification
The hardest cases to reach are a low-divisor write while the chain is already counting, and a mode write that lands during a run. Both need the counters part-way through a period at a known point. The stimulus arms the pacer with small divisors and lets several full periods pass. It then issues these writes at cycles that fall inside a period, and the reference model checks that the period is unchanged or that strobes stop. Trigger pulses of several widths, and trigger activity while stopped, cover the external path.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
   typedef enum logic [1:0] {
      SEL_MODE = 2'd0,
      SEL_LOW  = 2'd1,
      SEL_HIGH = 2'd2,
      SEL_NONE = 2'd3
   } pacer_sel_t;
endpackage

// File: rtl/pacer_prescale.sv
module pacer_prescale #(
   parameter int TICK_DIV = 25
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic run,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         logic unused_pins;
         assign unused_pins = ^{clk, rst, restart};
         assign tick = run;
      end else begin : g_count
         localparam int PW = $clog2(TICK_DIV);
         localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pcnt;
         assign tick = run && (pcnt == LAST);
         always_ff @(posedge clk) begin
            if (rst || restart)  pcnt <= '0;
            else if (tick)       pcnt <= '0;
            else if (run)        pcnt <= pcnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pacer_downcount.sv
module pacer_downcount #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             en,
   output logic             pulse
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt, reload_q;

   assign pulse = en && (cnt == ONE);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt      <= '0;
         reload_q <= '0;
      end else if (load) begin
         cnt      <= load_val;
         reload_q <= load_val;
      end else if (en && cnt != '0) begin
         cnt <= (cnt == ONE) ? reload_q : cnt - ONE;
      end
   end
endmodule

// File: rtl/pacer_edge_sync.sv
module pacer_edge_sync (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   logic s0, s1, s2;
   assign rise = s1 && !s2;
   always_ff @(posedge clk) begin
      if (rst) begin
         s0 <= 1'b0;
         s1 <= 1'b0;
         s2 <= 1'b0;
      end else begin
         s0 <= din;
         s1 <= s0;
         s2 <= s1;
      end
   end
endmodule

// File: rtl/pacer_cascade.sv
module pacer_cascade #(
   parameter int CNT_W    = 16,
   parameter int TICK_DIV = 25
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ext_trig,
   output logic             conv_strobe,
   output logic             running
);
   import pacer_pkg::*;

   localparam logic [CNT_W-1:0] DIV_MIN = CNT_W'(2);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pacer_cascade: CNT_W must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_tick
         $error("pacer_cascade: TICK_DIV must be at least 1");
      end
   endgenerate

   pacer_sel_t       sel;
   logic             armed, ext_mode, have_low;
   logic [CNT_W-1:0] low_div, wr_clamped;
   logic             mode_wr, low_wr, arm_now;
   logic             base_tick, low_pulse, high_pulse, ext_rise;

   assign sel        = pacer_sel_t'(wr_sel);
   assign wr_clamped = (wr_data < DIV_MIN) ? DIV_MIN : wr_data;
   assign mode_wr    = wr_en && (sel == SEL_MODE);
   assign low_wr     = wr_en && (sel == SEL_LOW);
   assign arm_now    = wr_en && (sel == SEL_HIGH) && have_low;
   assign running    = armed;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed    <= 1'b0;
         ext_mode <= 1'b0;
         have_low <= 1'b0;
         low_div  <= DIV_MIN;
      end else if (mode_wr) begin
         ext_mode <= wr_data[0];
         armed    <= 1'b0;
         have_low <= 1'b0;
      end else if (low_wr) begin
         low_div  <= wr_clamped;
         have_low <= 1'b1;
      end else if (arm_now) begin
         armed    <= 1'b1;
         have_low <= 1'b0;
      end
   end

   pacer_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
      .clk(clk), .rst(rst), .restart(mode_wr || arm_now),
      .run(armed), .tick(base_tick)
   );

   pacer_downcount #(.CNT_W(CNT_W)) u_low_cnt (
      .clk(clk), .rst(rst), .clr(mode_wr), .load(arm_now),
      .load_val(low_div), .en(base_tick), .pulse(low_pulse)
   );

   pacer_downcount #(.CNT_W(CNT_W)) u_high_cnt (
      .clk(clk), .rst(rst), .clr(mode_wr), .load(arm_now),
      .load_val(wr_clamped), .en(low_pulse), .pulse(high_pulse)
   );

   pacer_edge_sync u_ext_sync (
      .clk(clk), .rst(rst), .din(ext_trig), .rise(ext_rise)
   );

   always_ff @(posedge clk) begin
      if (rst) conv_strobe <= 1'b0;
      else     conv_strobe <= armed && (ext_mode ? ext_rise : high_pulse);
   end
endmodule

// File: rtl/pacer_cascade_chk.sv
module pacer_cascade_chk (
   input logic       clk,
   input logic       rst,
   input logic       wr_en,
   input logic [1:0] wr_sel,
   input logic       have_low,
   input logic       conv_strobe,
   input logic       running
);
   // R1
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!running && !conv_strobe));

   // R2
   a_r2_mode_write_stops: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd0) |=> !running);

   // R2, R7
   a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (rst)
      conv_strobe |-> $past(running));

   // R3
   a_r3_arm_after_low: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd2 && have_low) |=> running);

   // R3
   a_r3_no_arm_alone: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd2 && !have_low && !running) |=> !running);

   // R6
   a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
      conv_strobe |=> !conv_strobe);

   // R8
   a_r8_unused_sel: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd3) |=> $stable(running));
endmodule

bind pacer_cascade pacer_cascade_chk u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
   .have_low(have_low), .conv_strobe(conv_strobe), .running(running)
);

// File: tb/test_pacer_cascade.sv
module test_pacer_cascade;
   localparam int CNT_W    = 16;
   localparam int TICK_DIV = 25;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_sel = 2'd0;
   logic [CNT_W-1:0] wr_data = '0;
   logic             ext_trig = 1'b0;
   logic             conv_strobe, running;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    started = 1'b0;
   bit    done = 1'b0;
   string phase = "R1";

   // reference model state
   bit     m_armed, m_ext, m_pre, m_strobe;
   longint m_since, m_per, m_low;
   bit     x1, x2, x3;

   always #10 clk = ~clk;

   pacer_cascade #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) i_pacer_cascade (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ext_trig(ext_trig),
      .conv_strobe(conv_strobe), .running(running)
   );

   function automatic longint clampv(input longint v);
      return (v < 2) ? 2 : v;
   endfunction

   always @(posedge clk) begin
      started = 1'b1;
      if (rst) begin
         m_armed = 0; m_ext = 0; m_pre = 0; m_strobe = 0;
         m_since = 0; m_per = 1; m_low = 2;
         x1 = 0; x2 = 0; x3 = 0;
      end else begin
         m_strobe = m_armed && (m_ext ? (x2 && !x3)
                                      : (((m_since + 1) % m_per) == 0));
         if (m_armed) m_since++;
         x3 = x2; x2 = x1; x1 = ext_trig;
         if (wr_en) begin
            case (wr_sel)
               2'd0: begin m_ext = wr_data[0]; m_armed = 0; m_pre = 0; end
               2'd1: begin m_low = clampv(longint'(wr_data)); m_pre = 1; end
               2'd2: if (m_pre) begin
                  m_armed = 1; m_since = 0; m_pre = 0;
                  m_per = TICK_DIV * m_low * clampv(longint'(wr_data));
               end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         n_cmp++;
         if (conv_strobe !== m_strobe || running !== m_armed) begin
            n_bad++;
            $display("FAIL %s at %0t: strobe/running actual=%b/%b expected=%b/%b",
                     phase, $time, conv_strobe, running, m_strobe, m_armed);
         end
      end
   end

   task automatic wr(input logic [1:0] s, input logic [CNT_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ext_pulse(input int hi, input int lo);
      @(negedge clk); ext_trig = 1'b1;
      repeat (hi) @(negedge clk);
      ext_trig = 1'b0;
      repeat (lo) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      phase = "R1"; idle(3); rst = 1'b0; idle(20);
      phase = "R3"; wr(2'd2, 16'd3); idle(60);               // no arm without low
      phase = "R4"; wr(2'd1, 16'd2); wr(2'd2, 16'd3); idle(520); // period 150
      phase = "R9"; wr(2'd1, 16'd5); idle(330);              // period unchanged
      phase = "R8"; wr(2'd3, 16'd1); idle(160);
      phase = "R2"; idle(37); wr(2'd0, 16'd0); idle(220);    // stop mid-period
      phase = "R5"; wr(2'd1, 16'd1); wr(2'd2, 16'd0); idle(360); // period 100
      phase = "R9"; wr(2'd1, 16'd3); wr(2'd2, 16'd2); idle(330); // rearm, 150
      phase = "R7"; wr(2'd0, 16'd1); wr(2'd1, 16'd2); wr(2'd2, 16'd2);
      ext_pulse(1, 5); ext_pulse(4, 6); ext_pulse(30, 2); ext_pulse(2, 20);
      idle(260);                                             // no internal strobe
      phase = "R7"; wr(2'd0, 16'd1);
      ext_pulse(3, 5); ext_pulse(1, 8);                      // stopped: ignored
      phase = "R6"; wr(2'd0, 16'd0); wr(2'd1, 16'd0); wr(2'd2, 16'd0); idle(310);
      phase = "R1"; @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(40);
      finish_run();
   end
endmodule